// File: doc/BRIEF.md
# Limit Counter-Timer with Sticky Reached Flag

This block is a memory-mapped counter-timer for system use. An external tick pulse arrives once every 500 ns. On each tick the counter moves up by one step, and each step is worth 512 in register units because the count field starts at bit 9. The block compares the count with a programmable limit. When the count equals a nonzero limit, the next tick returns the count to zero, sets a sticky reached flag and raises a level interrupt. The interrupt stays high until software reads the limit register or writes a new limit.

Software reaches the block through a simple 32-bit word interface. There is one write strobe and one read strobe, and both act on the clock edge. The limit can be written at two addresses. One address restarts the count from zero. The other changes the limit and leaves the running count alone. A limit of zero selects free-run: the counter covers its whole range, wraps to zero and sets the flag at each wrap.

Top module: `limit_timer`

## Requirements
- R1: After reset the limit is 0, the count is 0, the reached flag is clear and `irq` is low. The counter then advances on ticks in free-run.
- R2: The word index is `addr[4:2]`. Index 0 is the restarting limit, 1 is the counter and 2 is the non-restarting limit. A read at index 3 to 7 returns zero, and a write there changes no state. `rdata` is zero while `rd_en` is low.
- R3: Each `tick` raises the count by one step. The count field occupies bits [9+PB-1:9] (bits 30:9 by default), and bits 8:0 always read zero. Without a tick the count holds.
- R4: A counter read returns the count field, with the reached flag in bit 31.
- R5: A write at index 0 stores `wdata[9+PB-1:9]` as the limit and drops all other bits. It sets the count to zero on that edge, even if a tick arrives in the same cycle. It also clears the flag and `irq`.
- R6: A write at index 2 stores the limit field in the same way and leaves the count running.
- R7: With a nonzero limit, a tick while the count equals the limit sets the count to 0 and sets the flag. `irq` is high from the next cycle on.
- R8: A limit read returns the limit field and clears the flag from the next cycle on. If a reach event occurs in the same cycle, the reach event wins.
- R9: With a limit of 0, the tick that arrives at the all-ones count wraps the count to 0 and sets the flag.
- R10: With a nonzero limit below the current count, the counter runs up to all-ones and wraps to 0 without setting the flag. It matches the limit afterwards.
- R11: `irq` follows the flag as a level and stays high until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick | input | 1 | One-cycle pulse, once per 500 ns |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (the limit read has a side effect) |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` while `rd_en` is high |
| irq | output | 1 | Level interrupt, equal to the reached flag |

## Verification
The hardest state to reach from the ports is a nonzero limit lying below the running count. This state needs the non-restarting write after the count has already passed the new limit. Only a full trip to the all-ones wrap then shows that the flag stays clear until the later match. The bench builds the timer with a narrow count field so that the wrap takes a few hundred ticks. A directed sequence counts up, lowers the limit through index 2, and walks through the wrap and on to the match. Random operations then mix ticks with reads and writes in the same cycle, which covers the collision of a restart write with a tick and of a limit read with a reach event.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int unsigned STEP_SHIFT = 9;
  localparam logic [2:0] IDX_LIMIT      = 3'd0;
  localparam logic [2:0] IDX_COUNT      = 3'd1;
  localparam logic [2:0] IDX_LIMIT_KEEP = 3'd2;

  function automatic logic [2:0] word_idx(input logic [4:0] a);
    return a[4:2];
  endfunction

  function automatic logic idx_mapped(input logic [2:0] i);
    return (i == IDX_LIMIT) || (i == IDX_COUNT) || (i == IDX_LIMIT_KEEP);
  endfunction
endpackage

// File: rtl/ltmr_bus_dec.sv
module ltmr_bus_dec
  import ltmr_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [4:0] addr,
  output logic [2:0] idx,
  output logic       wr_limit,
  output logic       wr_limit_keep,
  output logic       rd_limit,
  output logic       rd_count
);
  always_comb begin
    idx           = word_idx(addr);
    wr_limit      = wr_en && (idx == IDX_LIMIT);
    wr_limit_keep = wr_en && (idx == IDX_LIMIT_KEEP);
    rd_limit      = rd_en && (idx == IDX_LIMIT);
    rd_count      = rd_en && (idx == IDX_COUNT);
  end
endmodule

// File: rtl/ltmr_count_core.sv
module ltmr_count_core #(
  parameter int unsigned PB = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [PB-1:0] limit_q,
  output logic [PB-1:0] count_q,
  output logic          hit,
  output logic          wrap
);
  localparam logic [PB-1:0] TOP = {PB{1'b1}};

  function automatic logic [PB-1:0] step_count(input logic [PB-1:0] c,
                                               input logic          h,
                                               input logic          w);
    if (h || w) return '0;
    return c + 1'b1;
  endfunction

  always_comb begin
    hit  = tick && !restart && (limit_q != '0) && (count_q == limit_q);
    wrap = tick && !restart && !hit && (count_q == TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (restart) count_q <= '0;
    else if (tick)    count_q <= step_count(count_q, hit, wrap);
  end
endmodule

// File: rtl/ltmr_flag.sv
module ltmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end
endmodule

// File: rtl/limit_timer.sv
module limit_timer
  import ltmr_pkg::*;
#(
  parameter int unsigned PB = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int unsigned SH = STEP_SHIFT;

  logic [2:0]    idx;
  logic          wr_limit, wr_limit_keep, rd_limit, rd_count;
  logic [PB-1:0] limit_q, count_q;
  logic          hit, wrap, reach_evt, clr_evt, flag_q;

  ltmr_bus_dec u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .idx(idx),
    .wr_limit(wr_limit), .wr_limit_keep(wr_limit_keep),
    .rd_limit(rd_limit), .rd_count(rd_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) limit_q <= '0;
    else if (wr_limit || wr_limit_keep) limit_q <= wdata[SH +: PB];
  end

  ltmr_count_core #(.PB(PB)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(wr_limit),
    .limit_q(limit_q), .count_q(count_q), .hit(hit), .wrap(wrap)
  );

  always_comb begin
    reach_evt = hit || (wrap && (limit_q == '0));
    clr_evt   = rd_limit || wr_limit;
  end

  ltmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(reach_evt), .clr_evt(clr_evt),
    .flag_q(flag_q)
  );

  always_comb begin
    rdata = '0;
    if (rd_limit) rdata[SH +: PB] = limit_q;
    if (rd_count) begin
      rdata[SH +: PB] = count_q;
      rdata[31]       = flag_q;
    end
  end

  assign irq = flag_q;
endmodule

// File: rtl/ltmr_chk.sv
module ltmr_chk #(
  parameter int unsigned PB = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          rd_en,
  input logic [4:0]    addr,
  input logic [31:0]   rdata,
  input logic          irq,
  input logic [PB-1:0] count_q,
  input logic          hit,
  input logic          wrap,
  input logic          reach_evt,
  input logic          wr_limit,
  input logic          rd_limit
);
  // R7
  reach_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reach_evt |=> irq);
  // R7
  hit_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (count_q == '0));
  // R8
  limit_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_limit && !reach_evt) |=> !irq);
  // R5
  restart_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_limit |=> ((count_q == '0) && !irq));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_limit && !hit && !wrap) |=> (count_q == $past(count_q) + 1'b1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_limit) |=> $stable(count_q));
  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:2] == 3'd1) |-> (rdata[8:0] == 9'd0));
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en && addr[4:2] > 3'd2) || !rd_en) |-> (rdata == 32'd0));
endmodule

bind limit_timer ltmr_chk #(.PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq(irq), .count_q(count_q), .hit(hit), .wrap(wrap),
  .reach_evt(reach_evt), .wr_limit(wr_limit), .rd_limit(rd_limit)
);

// File: tb/limit_timer_test.sv
module limit_timer_test;
  localparam int unsigned PB  = 8;
  localparam int unsigned TOP = (1 << PB) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;

  int unsigned m_lim = 0, m_cnt = 0;
  bit m_flag = 0;

  always #5 clk = ~clk;

  limit_timer #(.PB(PB)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] expect_read(input logic [4:0] a);
    case (a[4:2])
      3'd0: return 32'(m_lim) << 9;
      3'd1: return {m_flag, 31'(m_cnt * 512)};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int unsigned field_of(input logic [31:0] d);
    return (d >> 9) & TOP;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit we, input bit re,
                      input logic [4:0] a, input logic [31:0] d, input string req);
    bit rst_w, hitm, wrapm, setm;
    @(negedge clk);
    tick = tk; wr_en = we; rd_en = re; addr = a; wdata = d;
    #1;
    if (re) check32(req, rdata, expect_read(a));
    else    check32("R2 idle rdata", rdata, 32'd0);
    check32("R11 irq level", {31'd0, irq}, {31'd0, m_flag});
    @(posedge clk);
    #1;
    rst_w = we && a[4:2] == 3'd0;
    hitm  = tk && !rst_w && m_lim != 0 && m_cnt == m_lim;
    wrapm = tk && !rst_w && !hitm && m_cnt == TOP;
    setm  = hitm || (wrapm && m_lim == 0);
    if (rst_w) m_cnt = 0;
    else if (tk) m_cnt = (hitm || wrapm) ? 0 : m_cnt + 1;
    if (we && (a[4:2] == 3'd0 || a[4:2] == 3'd2)) m_lim = field_of(d);
    if (setm) m_flag = 1;
    else if ((re && a[4:2] == 3'd0) || rst_w) m_flag = 0;
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1, 0, 0, 5'd0, 32'd0, req);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(0, 0, 1, 5'h00, 0, "R1 limit after reset");
    step(0, 0, 1, 5'h04, 0, "R1 counter after reset");
    check32("R1 irq low", {31'd0, irq}, 32'd0);
    ticks(3, "R1 runs after reset");
    step(0, 0, 1, 5'h04, 0, "R1 counts free-run");
    check32("R3 three steps", rdata, 32'h0000_0600);
    // R5 restart write with garbage low bits and a tick in the same cycle
    step(1, 1, 0, 5'h00, 32'hF000_07FF, "R5 write");
    step(0, 0, 1, 5'h00, 0, "R5 limit masked");
    check32("R5 masked value", rdata, 32'h0000_0600);
    step(0, 0, 1, 5'h04, 0, "R5 count restarted");
    check32("R5 count zero", rdata, 32'd0);
    // R7 match at limit 3
    ticks(3, "R3 step");
    step(0, 0, 1, 5'h04, 0, "R3 count at limit");
    step(1, 0, 0, 5'h00, 0, "R7 match tick");
    check32("R7 irq high", {31'd0, irq}, 32'd1);
    step(0, 0, 1, 5'h04, 0, "R4 flag in bit 31");
    check32("R4 direct", rdata, 32'h8000_0000);
    // R2 unmapped access leaves state
    step(0, 1, 0, 5'h0C, 32'hFFFF_FFFF, "R2 unmapped write");
    step(0, 1, 0, 5'h1C, 32'hFFFF_FFFF, "R2 unmapped write");
    step(0, 0, 1, 5'h10, 0, "R2 unmapped read");
    step(0, 0, 1, 5'h14, 0, "R2 unmapped read");
    step(0, 0, 1, 5'h04, 0, "R2 state kept");
    step(0, 0, 1, 5'h00, 0, "R2 limit kept");
    // R8 read clears flag
    step(0, 0, 1, 5'h04, 0, "R8 flag cleared");
    check32("R8 irq low", {31'd0, irq}, 32'd0);
    // R8 reach and limit read in the same cycle: reach wins
    ticks(3, "R3 step");
    step(1, 0, 1, 5'h00, 0, "R8 collide read");
    check32("R8 reach wins", {31'd0, irq}, 32'd1);
    step(0, 0, 1, 5'h00, 0, "R8 clear");
    // R10 lower limit below count via index 2
    step(0, 1, 0, 5'h00, 32'd10 << 9, "R5 set 10");
    ticks(6, "R3 step");
    step(0, 1, 0, 5'h08, 32'd2 << 9, "R6 keep write");
    step(0, 0, 1, 5'h04, 0, "R6 count kept");
    check32("R6 count 6", rdata, 32'd6 << 9);
    ticks(TOP - 6, "R10 run up");
    step(0, 0, 1, 5'h04, 0, "R10 at top");
    step(1, 0, 0, 5'h00, 0, "R10 wrap");
    step(0, 0, 1, 5'h04, 0, "R10 wrapped no flag");
    check32("R10 direct", rdata, 32'd0);
    ticks(2, "R10 climb");
    step(1, 0, 0, 5'h00, 0, "R10 match");
    check32("R10 flag after match", {31'd0, irq}, 32'd1);
    // R9 free-run wrap sets flag
    step(0, 1, 0, 5'h00, 32'd0, "R9 limit zero");
    ticks(TOP, "R9 run up");
    step(0, 0, 1, 5'h04, 0, "R9 at top");
    step(1, 0, 0, 5'h00, 0, "R9 wrap");
    step(0, 0, 1, 5'h04, 0, "R9 flag set");
    check32("R9 direct", rdata, 32'h8000_0000);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom % 8;
      bit tk = ($urandom % 3) != 0;
      logic [31:0] d = {$urandom} & 32'h0000_FFFF;
      if ($urandom % 4 == 0) d = ($urandom % 24) << 9 | ($urandom % 512);
      case (op)
        0: step(tk, 1, 0, 5'h00, d, "R5 random");
        1: step(tk, 1, 0, 5'h08, d, "R6 random");
        2, 3: step(tk, 0, 1, 5'h04, 0, "R4 random");
        4: step(tk, 0, 1, 5'h00, 0, "R8 random");
        5: step(tk, ($urandom % 2) == 1, ($urandom % 2) == 1,
                5'(($urandom % 5 + 3) << 2), d, "R2 random");
        default: step(tk, 0, 0, 5'h00, 0, "R3 random");
      endcase
    end
    summary();
  end
endmodule